// File: doc/BRIEF.md
# Counter Array Shared Timebase

This block is the common free-running count that a bank of five capture/compare units reads as their time reference. It holds a 16-bit value, split into a low byte and a high byte. Software can load each byte on its own. The count advances by one on each tick of the source that a 2-bit selector picks. The four sources are:

- the system clock divided by twelve;
- the system clock divided by four;
- a one-cycle overflow pulse from a neighbouring timer;
- an external pin, brought into the clock domain through a two-flop synchronizer and counted on its falling edge.

The capture/compare units take the full 16-bit value from `count_o`. When the count rolls over from all ones to zero, they see a one-cycle pulse on `ovf_pulse`. The same roll-over sets a sticky flag. The flag raises an interrupt request while the overflow interrupt is enabled, and it stays set until software clears it. Software reads the count one byte at a time through a byte selector.

Top module: `pca_timebase`

## Requirements
- R1: After reset, the count is 0x0000 and both `ovf_flag` and `irq` are low.
- R2: With `src_sel` = 2'b00 and `run_en` high, the count rises by exactly one for every 12 clock cycles.
- R3: With `src_sel` = 2'b01 and `run_en` high, the count rises by exactly one for every 4 clock cycles.
- R4: With `src_sel` = 2'b10 and `run_en` high, the count rises by one on each rising clock edge at which `tmr_ovf_tick` is high.
- R5: With `src_sel` = 2'b11 and `run_en` high, a high-to-low change of `ext_clk_pin` that is set up before a rising clock edge raises the count by one at the third rising edge from that one. A low-to-high change of the pin never counts.
- R6: While `run_en` is low and no byte is being written, the count holds, whatever the selected source does.
- R7: A write pulse on `wr_lo` or `wr_hi` loads `wr_data` into the low or high byte at the next rising edge. The other byte is left unchanged. A write wins over a count tick in the same cycle.
- R8: A count step from 0xFFFF to 0x0000 sets `ovf_flag`. In the same cycle that the count shows 0x0000, `ovf_pulse` is high, for exactly one cycle.
- R9: `ovf_flag` stays set until a cycle with `ovf_clr` high. If a roll-over happens in the same cycle as the clear, the roll-over wins and the flag stays set.
- R10: `irq` is high exactly when `ovf_flag` is set and `ovf_irq_en` is high.
- R11: `rd_data` shows the low byte when `rd_sel` = 0 and the high byte when `rd_sel` = 1. `count_o` always carries the full 16-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Count source: 00 clock/12, 01 clock/4, 10 timer overflow, 11 external pin |
| run_en | input | 1 | Count enable |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| wr_lo | input | 1 | Load the low byte from `wr_data` |
| wr_hi | input | 1 | Load the high byte from `wr_data` |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 1 | Byte selector for `rd_data` (0 low, 1 high) |
| rd_data | output | 8 | Selected count byte |
| tmr_ovf_tick | input | 1 | One-cycle overflow pulse from another timer |
| ext_clk_pin | input | 1 | Asynchronous external count pin |
| ovf_clr | input | 1 | Clear the overflow flag |
| count_o | output | 16 | Full count for the capture/compare units |
| ovf_pulse | output | 1 | One-cycle roll-over event |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
Most internal faults reach the ports quickly:

- A prescaler running at the wrong ratio or phase shows up as a wrong count difference over any window that is a multiple of the source period. The error appears within one or two periods.
- A wrong pick in the source mux makes the count follow another source, visible within a few ticks.
- A missing or extra synchronizer stage moves the external-pin increment by one edge. The single-edge latency check catches this at once.
- A flag that is not sticky, or loses to a clear, shows on `ovf_flag` one cycle after the roll-over.

// File: rtl/pcatb_pkg.sv
package pcatb_pkg;
  typedef enum logic [1:0] {
    SRC_DIV_SLOW = 2'b00,
    SRC_DIV_FAST = 2'b01,
    SRC_TMR_OVF  = 2'b10,
    SRC_EXT_PIN  = 2'b11
  } src_e;

  localparam int unsigned DEF_BYTE_W   = 8;
  localparam int unsigned DEF_DIV_SLOW = 12;
  localparam int unsigned DEF_DIV_FAST = 4;
  localparam int unsigned DEF_SYNC     = 2;
endpackage

// File: rtl/pcatb_divider.sv
module pcatb_divider #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  function automatic logic [PW-1:0] f_next_phase(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= f_next_phase(phase);
  end

  assign tick = (phase == LAST);
endmodule

// File: rtl/pcatb_extsync.sv
module pcatb_extsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= pin;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/pcatb_counter.sv
module pcatb_counter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_en,
  input  logic                  tick,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic                  ovf_clr,
  output logic [2*BYTE_W-1:0]   count,
  output logic                  ovf_flag,
  output logic                  ovf_pulse,
  output logic                  wrap_evt
);
  localparam int unsigned CW = 2 * BYTE_W;

  function automatic logic [CW-1:0] f_step(input logic [CW-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic f_at_top(input logic [CW-1:0] c);
    return &c;
  endfunction

  function automatic logic [CW-1:0] f_load(input logic [CW-1:0] c,
                                          input logic lo, input logic hi,
                                          input logic [BYTE_W-1:0] d);
    logic [CW-1:0] r;
    r = c;
    if (lo) r[BYTE_W-1:0]  = d;
    if (hi) r[CW-1:BYTE_W] = d;
    return r;
  endfunction

  logic any_wr;
  logic step_en;

  assign any_wr   = wr_lo | wr_hi;
  assign step_en  = run_en & tick & ~any_wr;
  assign wrap_evt = step_en & f_at_top(count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      ovf_flag  <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      if (any_wr)       count <= f_load(count, wr_lo, wr_hi, wr_data);
      else if (step_en) count <= f_step(count);
      ovf_pulse <= wrap_evt;
      if (wrap_evt)     ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pcatb_pkg::*;
#(
  parameter int unsigned BYTE_W   = DEF_BYTE_W,
  parameter int unsigned DIV_SLOW = DEF_DIV_SLOW,
  parameter int unsigned DIV_FAST = DEF_DIV_FAST,
  parameter int unsigned SYNC     = DEF_SYNC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          src_sel,
  input  logic                run_en,
  input  logic                ovf_irq_en,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                rd_sel,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic                tmr_ovf_tick,
  input  logic                ext_clk_pin,
  input  logic                ovf_clr,
  output logic [2*BYTE_W-1:0] count_o,
  output logic                ovf_pulse,
  output logic                ovf_flag,
  output logic                irq
);
  localparam int unsigned CW = 2 * BYTE_W;

  logic tick_slow, tick_fast, ext_fall, sel_tick, wrap_evt;
  src_e src;

  assign src = src_e'(src_sel);

  pcatb_divider #(.DIV(DIV_SLOW)) u_div_slow (.clk(clk), .rst_n(rst_n), .tick(tick_slow));
  pcatb_divider #(.DIV(DIV_FAST)) u_div_fast (.clk(clk), .rst_n(rst_n), .tick(tick_fast));

  pcatb_extsync #(.STAGES(SYNC)) u_ext (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk_pin), .fall(ext_fall)
  );

  always_comb begin
    unique case (src)
      SRC_DIV_SLOW: sel_tick = tick_slow;
      SRC_DIV_FAST: sel_tick = tick_fast;
      SRC_TMR_OVF:  sel_tick = tmr_ovf_tick;
      default:      sel_tick = ext_fall;
    endcase
  end

  pcatb_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(sel_tick),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .count(count_o), .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse),
    .wrap_evt(wrap_evt)
  );

  assign rd_data = rd_sel ? count_o[CW-1:BYTE_W] : count_o[BYTE_W-1:0];
  assign irq     = ovf_flag & ovf_irq_en;
endmodule

// File: rtl/pcatb_checker.sv
module pcatb_checker #(
  parameter int unsigned BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run_en,
  input logic                wr_lo,
  input logic                wr_hi,
  input logic [BYTE_W-1:0]   wr_data,
  input logic                ovf_clr,
  input logic                ovf_irq_en,
  input logic [2*BYTE_W-1:0] count_o,
  input logic                ovf_flag,
  input logic                ovf_pulse,
  input logic                irq,
  input logic                sel_tick,
  input logic                wrap_evt
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_lo && !wr_hi) |=> $stable(count_o)); // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && sel_tick && !wr_lo && !wr_hi) |=> count_o == $past(count_o) + 1'b1); // R2
  AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> count_o[BYTE_W-1:0] == $past(wr_data)); // R7
  AST_LOAD_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> count_o[BYTE_W-1:0] == $past(count_o[BYTE_W-1:0])); // R7
  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (ovf_flag && ovf_pulse && count_o == '0)); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag && ovf_irq_en)); // R10
endmodule

bind pca_timebase pcatb_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_lo(wr_lo), .wr_hi(wr_hi),
  .wr_data(wr_data), .ovf_clr(ovf_clr), .ovf_irq_en(ovf_irq_en),
  .count_o(count_o), .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse), .irq(irq),
  .sel_tick(sel_tick), .wrap_evt(wrap_evt)
);

// File: tb/pca_timebase_tb.sv
module pca_timebase_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic run_en = 1'b0, ovf_irq_en = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rd_sel = 1'b0, ovf_clr = 1'b0;
  logic tmr_auto = 1'b1, ext_auto = 1'b1, tmr_man = 1'b0, ext_man = 1'b1;
  logic tmr_bg = 1'b0, ext_bg = 1'b1;
  logic tmr_ovf_tick, ext_clk_pin;
  logic [7:0] rd_data;
  logic [15:0] count_o;
  logic ovf_pulse, ovf_flag, irq;
  int total = 0, bad = 0;
  int bg_cnt = 0;

  always #2.5 clk = ~clk;

  assign tmr_ovf_tick = tmr_auto ? tmr_bg : tmr_man;
  assign ext_clk_pin  = ext_auto ? ext_bg : ext_man;

  always @(negedge clk) begin
    bg_cnt <= bg_cnt + 1;
    tmr_bg <= ((bg_cnt + 1) % 3 == 0);
    if ((bg_cnt + 1) % 4 == 0) ext_bg <= ~ext_bg;
  end

  pca_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .run_en(run_en),
    .ovf_irq_en(ovf_irq_en), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tmr_ovf_tick(tmr_ovf_tick),
    .ext_clk_pin(ext_clk_pin), .ovf_clr(ovf_clr), .count_o(count_o),
    .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // vector: src[18:17] run[16] cycles[15:8] expected delta[7:0]
  localparam logic [18:0] VEC [8] = '{
    {2'b00, 1'b1, 8'd48, 8'd4},   // R2
    {2'b01, 1'b1, 8'd48, 8'd12},  // R3
    {2'b10, 1'b1, 8'd48, 8'd16},  // R4
    {2'b11, 1'b1, 8'd48, 8'd6},   // R5
    {2'b01, 1'b0, 8'd48, 8'd0},   // R6
    {2'b00, 1'b1, 8'd24, 8'd2},   // R2
    {2'b11, 1'b1, 8'd24, 8'd3},   // R5
    {2'b10, 1'b1, 8'd24, 8'd8}    // R4
  };

  task automatic write_bytes(input logic lo, input logic hi, input logic [7:0] d);
    wr_lo = lo; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", count_o, 16'h0000);
    check("R1 flag", {15'b0, ovf_flag}, 16'h0);
    check("R1 irq", {15'b0, irq}, 16'h0);

    for (int v = 0; v < 8; v++) begin
      src_sel = VEC[v][18:17];
      run_en  = VEC[v][16];
      c0 = count_o;
      repeat (int'(VEC[v][15:8])) @(negedge clk);
      check($sformatf("R2-6 vector %0d delta", v), count_o - c0, {8'h00, VEC[v][7:0]});
    end
    run_en = 1'b0;

    // R11 byte read and R7 bytewise writes
    tmr_auto = 1'b0; ext_auto = 1'b0; ext_man = 1'b1;
    write_bytes(1'b1, 1'b0, 8'h34);
    write_bytes(1'b0, 1'b1, 8'h12);
    check("R7 both bytes", count_o, 16'h1234);
    rd_sel = 1'b0; #1;
    check("R11 low byte", {8'h00, rd_data}, 16'h0034);
    rd_sel = 1'b1; #1;
    check("R11 high byte", {8'h00, rd_data}, 16'h0012);

    // R6 run low ignores ticks
    src_sel = 2'b10; tmr_man = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 hold with ticks", count_o, 16'h1234);

    // R7 write overrides simultaneous tick
    run_en = 1'b1;
    write_bytes(1'b1, 1'b0, 8'h55);
    check("R7 write beats tick", count_o, 16'h1255);
    tmr_man = 1'b0;
    @(negedge clk);
    check("R4 no tick no step", count_o, 16'h1255);

    // R8 wrap
    ovf_irq_en = 1'b1;
    write_bytes(1'b1, 1'b1, 8'hFF);
    check("R8 preload", count_o, 16'hFFFF);
    tmr_man = 1'b1;
    @(negedge clk);
    tmr_man = 1'b0;
    check("R8 wrapped", count_o, 16'h0000);
    check("R8 pulse", {15'b0, ovf_pulse}, 16'h1);
    check("R8 flag", {15'b0, ovf_flag}, 16'h1);
    check("R10 irq on", {15'b0, irq}, 16'h1);
    @(negedge clk);
    check("R8 pulse one cycle", {15'b0, ovf_pulse}, 16'h0);
    check("R9 flag sticky", {15'b0, ovf_flag}, 16'h1);
    ovf_irq_en = 1'b0; #1;
    check("R10 irq masked", {15'b0, irq}, 16'h0);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R9 cleared", {15'b0, ovf_flag}, 16'h0);

    // R9 set wins over clear
    write_bytes(1'b1, 1'b1, 8'hFF);
    tmr_man = 1'b1; ovf_clr = 1'b1;
    @(negedge clk);
    tmr_man = 1'b0; ovf_clr = 1'b0;
    check("R9 set beats clear", {15'b0, ovf_flag}, 16'h1);

    // R5 latency of one falling edge
    src_sel = 2'b11; ext_man = 1'b1;
    repeat (4) @(negedge clk);
    c0 = count_o;
    ext_man = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R5 not yet after two edges", count_o, c0);
    @(negedge clk);
    check("R5 step at third edge", count_o, c0 + 16'd1);
    ext_man = 1'b1;
    repeat (5) @(negedge clk);
    check("R5 rising edge ignored", count_o, c0 + 16'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule